// File: doc/BRIEF.md
# Rectangular Window Pixel Loader

This block takes 16-bit words from a host data port and places them into a rectangle of a word-addressed frame buffer. Software first programs the rectangle's corner coordinates, a pixel format code, a rotation setting and a source selector through a small register port. The block then checks the setup, works out the window size and the number of words the transfer needs, and accepts exactly that many words. Each accepted word becomes one frame buffer write. A one-cycle pulse marks the end of the transfer.

A transfer starts in one of two ways. Software can write the source selector, or it can write a data word while no transfer is open; in the second case the block sets itself up from the registers it already holds. When a transfer completes, the block grows a dirty bounding box that later display refresh logic can read to find the region that changed.

Register select codes on `reg_sel`: 0 X start, 1 X end, 2 Y start, 3 Y end, 4 format code (low 4 bits), 5 source selector (low 3 bits), 6 effects (low 2 bits give the rotation angle).

Top module: `win_loader`

## Requirements
- R1: The format code sets the bytes per pixel: code 1 gives 2, codes 2 and 3 give 3, codes 6 and 7 give 4. Every other code gives 0, and a setup with 0 bytes per pixel is rejected.
- R2: A setup is rejected if the source selector is above 3, if X end is below X start, or if Y end is below Y start. A rejected setup on a source write leaves `busy` and any open transfer unchanged.
- R3: The transfer length in words is floor(bpp × (xend − xstart + 1) × (yend − ystart + 1) / 2). The last of those words raises `done` for exactly one cycle, in the cycle after the word, and `busy` falls in that same cycle.
- R4: A source write (select code 5) whose setup is valid raises `busy` in the next cycle and restarts the word count and the cursor, even while a transfer is open.
- R5: A data word that arrives with no transfer open starts a transfer from the stored registers and counts as its first word. If that setup is rejected, the word is dropped: no frame buffer write and no change to `busy`.
- R6: Each accepted word produces `fb_we` one cycle later, carrying the same word, at address y × PANEL_W + x. The cursor starts at (X start, Y start), moves right one slot per word, and after X end returns to X start on the next row.
- R7: At reset the dirty box is x0 = y0 = 2^(COORD_W+1) − 1 and x1 = y1 = 0. On each commit, x0 and y0 become the minimum of themselves and the window start, and x1 and y1 become the maximum of themselves and start + size (exclusive end). Nothing else changes the box.
- R8: `fb_angle` carries effects bits [1:0] as captured at setup, alongside each frame buffer write. `fb_rot` is 1 exactly when that angle is nonzero.
- R9: The window extents and the rotation are captured at setup. Register writes during an open transfer do not change that transfer's addresses or its length.
- R10: After reset, `busy`, `done` and `fb_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | COORD_W | Register write value |
| dat_we | input | 1 | Data port word strobe |
| dat_word | input | DATA_W | Data port word |
| busy | output | 1 | A transfer is open |
| done | output | 1 | One-cycle pulse when the last word is committed |
| fb_we | output | 1 | Frame buffer write strobe |
| fb_addr | output | ADDR_W | Frame buffer word address |
| fb_word | output | DATA_W | Frame buffer write data |
| fb_angle | output | 2 | Rotation angle of the current write |
| fb_rot | output | 1 | Rotated path selected |
| dirty_x0 | output | COORD_W+1 | Dirty box left edge |
| dirty_y0 | output | COORD_W+1 | Dirty box top edge |
| dirty_x1 | output | COORD_W+1 | Dirty box right edge, exclusive |
| dirty_y1 | output | COORD_W+1 | Dirty box bottom edge, exclusive |

## Verification
The bench targets a one-word window opened by a bare data word. A design that forgets to count the arming word would keep `busy` high and wait for a word that never comes. It checks 3-byte formats where the halving rounds down, so an off-by-one in the length would end the transfer one word early or late. It sends a rejected source write in the middle of a transfer, which a careless design would let abort the transfer. It also sends a valid source write in the middle of a transfer; a design that keeps the old cursor would write to the wrong address. Changing X end during a transfer exposes a design that reads the live register instead of the captured extent, because its row wrap moves.

// File: rtl/wl_pkg.sv
package wl_pkg;

  typedef enum logic [2:0] {
    SEL_XS  = 3'd0,
    SEL_XE  = 3'd1,
    SEL_YS  = 3'd2,
    SEL_YE  = 3'd3,
    SEL_FMT = 3'd4,
    SEL_SRC = 3'd5,
    SEL_FX  = 3'd6
  } sel_e;

  // format code to bytes per pixel; zero marks an unsupported code
  function automatic logic [2:0] bytes_per_px(input logic [3:0] code);
    case (code)
      4'd1:        return 3'd2;
      4'd2, 4'd3:  return 3'd3;
      4'd6, 4'd7:  return 3'd4;
      default:     return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/wl_setup.sv
module wl_setup #(
  parameter int COORD_W = 10,
  parameter int CNT_W   = 2 * COORD_W + 2
) (
  input  logic [COORD_W-1:0] xs,
  input  logic [COORD_W-1:0] xe,
  input  logic [COORD_W-1:0] ys,
  input  logic [COORD_W-1:0] ye,
  input  logic [3:0]         fmt,
  input  logic [2:0]         src,
  output logic               ok,
  output logic [COORD_W:0]   w,
  output logic [COORD_W:0]   h,
  output logic [CNT_W-1:0]   total
);
  import wl_pkg::*;

  localparam int PW = CNT_W + 1;

  function automatic logic [COORD_W:0] span(input logic [COORD_W-1:0] a,
                                            input logic [COORD_W-1:0] b);
    return {1'b0, b} - {1'b0, a} + (COORD_W+1)'(1);
  endfunction

  function automatic logic [CNT_W-1:0] word_count(input logic [2:0] bpp,
                                                  input logic [COORD_W:0] cw,
                                                  input logic [COORD_W:0] ch);
    logic [PW-1:0] prod;
    prod = PW'(bpp) * PW'(cw) * PW'(ch);
    return prod[PW-1:1];
  endfunction

  logic [2:0] bpp;

  always_comb begin
    bpp   = bytes_per_px(fmt);
    w     = span(xs, xe);
    h     = span(ys, ye);
    total = word_count(bpp, w, h);
    ok    = (src <= 3'd3) && (bpp != 3'd0) && (xe >= xs) && (ye >= ys);
  end

endmodule

// File: rtl/wl_count.sv
module wl_count #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             arm,
  input  logic             step,
  input  logic [CNT_W-1:0] total,
  output logic             busy,
  output logic             done,
  output logic             last
);
  logic [CNT_W-1:0] remain;

  always_comb
    last = step && (arm ? (total == CNT_W'(1)) : (remain == CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= last;
      if (load) begin
        remain <= total;
        busy   <= 1'b1;
      end else if (step) begin
        remain <= (arm ? total : remain) - CNT_W'(1);
        busy   <= !last;
      end
    end
  end

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (remain != '0));

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/wl_cursor.sv
module wl_cursor #(
  parameter int COORD_W = 10,
  parameter int PANEL_W = 640,
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               arm,
  input  logic               step,
  input  logic [COORD_W-1:0] e_xs,
  input  logic [COORD_W-1:0] e_xe,
  input  logic [COORD_W-1:0] e_ys,
  input  logic [1:0]         e_rot,
  input  logic [DATA_W-1:0]  word,
  output logic               fb_we,
  output logic [ADDR_W-1:0]  fb_addr,
  output logic [DATA_W-1:0]  fb_word,
  output logic [1:0]         fb_angle,
  output logic               fb_rot
);
  function automatic logic [ADDR_W-1:0] lin_addr(input logic [COORD_W-1:0] x,
                                                 input logic [COORD_W-1:0] y);
    return ADDR_W'(y) * ADDR_W'(PANEL_W) + ADDR_W'(x);
  endfunction

  logic [COORD_W-1:0] cx, cy, px, py, nx, ny;

  always_comb begin
    px = arm ? e_xs : cx;
    py = arm ? e_ys : cy;
    if (px == e_xe) begin
      nx = e_xs;
      ny = py + COORD_W'(1);
    end else begin
      nx = px + COORD_W'(1);
      ny = py;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cx       <= '0;
      cy       <= '0;
      fb_we    <= 1'b0;
      fb_addr  <= '0;
      fb_word  <= '0;
      fb_angle <= 2'd0;
      fb_rot   <= 1'b0;
    end else begin
      fb_we <= step;
      if (load) begin
        cx <= e_xs;
        cy <= e_ys;
      end else if (step) begin
        cx       <= nx;
        cy       <= ny;
        fb_addr  <= lin_addr(px, py);
        fb_word  <= word;
        fb_angle <= e_rot;
        fb_rot   <= (e_rot != 2'd0);
      end
    end
  end

endmodule

// File: rtl/wl_dirty.sv
module wl_dirty #(
  parameter int COORD_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [COORD_W-1:0] xs,
  input  logic [COORD_W-1:0] ys,
  input  logic [COORD_W:0]   w,
  input  logic [COORD_W:0]   h,
  output logic [COORD_W:0]   x0,
  output logic [COORD_W:0]   y0,
  output logic [COORD_W:0]   x1,
  output logic [COORD_W:0]   y1
);
  localparam int DW = COORD_W + 1;

  function automatic logic [DW-1:0] lo(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return (b < a) ? b : a;
  endfunction

  function automatic logic [DW-1:0] hi(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return (b > a) ? b : a;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x0 <= '1;
      y0 <= '1;
      x1 <= '0;
      y1 <= '0;
    end else if (commit) begin
      x0 <= lo(x0, {1'b0, xs});
      y0 <= lo(y0, {1'b0, ys});
      x1 <= hi(x1, {1'b0, xs} + w);
      y1 <= hi(y1, {1'b0, ys} + h);
    end
  end

  // R7
  no_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (x0 <= $past(x0)) && (y0 <= $past(y0)) &&
             (x1 >= $past(x1)) && (y1 >= $past(y1)));

endmodule

// File: rtl/win_loader.sv
module win_loader #(
  parameter int COORD_W = 10,
  parameter int PANEL_W = 640,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = $clog2(PANEL_W * (1 << COORD_W))
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [2:0]         reg_sel,
  input  logic [COORD_W-1:0] reg_wdata,
  input  logic               dat_we,
  input  logic [DATA_W-1:0]  dat_word,
  output logic               busy,
  output logic               done,
  output logic               fb_we,
  output logic [ADDR_W-1:0]  fb_addr,
  output logic [DATA_W-1:0]  fb_word,
  output logic [1:0]         fb_angle,
  output logic               fb_rot,
  output logic [COORD_W:0]   dirty_x0,
  output logic [COORD_W:0]   dirty_y0,
  output logic [COORD_W:0]   dirty_x1,
  output logic [COORD_W:0]   dirty_y1
);
  import wl_pkg::*;

  localparam int CNT_W = 2 * COORD_W + 2;

  // programmed registers
  logic [COORD_W-1:0] r_xs, r_xe, r_ys, r_ye;
  logic [3:0]         r_fmt;
  logic [2:0]         r_src;
  logic [1:0]         r_fx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_xs  <= '0;
      r_xe  <= '0;
      r_ys  <= '0;
      r_ye  <= '0;
      r_fmt <= 4'd3;
      r_src <= 3'd0;
      r_fx  <= 2'd0;
    end else if (reg_we) begin
      case (sel_e'(reg_sel))
        SEL_XS:  r_xs  <= reg_wdata;
        SEL_XE:  r_xe  <= reg_wdata;
        SEL_YS:  r_ys  <= reg_wdata;
        SEL_YE:  r_ye  <= reg_wdata;
        SEL_FMT: r_fmt <= reg_wdata[3:0];
        SEL_SRC: r_src <= reg_wdata[2:0];
        SEL_FX:  r_fx  <= reg_wdata[1:0];
        default: ;
      endcase
    end
  end

  // setup evaluation; a source write is judged on the value being written
  logic               src_wr;
  logic [2:0]         src_in;
  logic               s_ok;
  logic [COORD_W:0]   s_w, s_h;
  logic [CNT_W-1:0]   s_total;

  always_comb begin
    src_wr = reg_we && (reg_sel == SEL_SRC);
    src_in = src_wr ? reg_wdata[2:0] : r_src;
  end

  wl_setup #(.COORD_W(COORD_W), .CNT_W(CNT_W)) u_setup (
    .xs(r_xs), .xe(r_xe), .ys(r_ys), .ye(r_ye), .fmt(r_fmt), .src(src_in),
    .ok(s_ok), .w(s_w), .h(s_h), .total(s_total)
  );

  // transfer control events
  logic load_ev, arm_ev, step_ev, last_ev, fresh;

  always_comb begin
    load_ev = src_wr && s_ok;
    arm_ev  = dat_we && !src_wr && !busy && s_ok;
    step_ev = dat_we && !src_wr && (busy || s_ok);
    fresh   = load_ev || arm_ev;
  end

  // window captured at setup
  logic [COORD_W-1:0] q_xs, q_xe, q_ys;
  logic [COORD_W:0]   q_w, q_h;
  logic [1:0]         q_rot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_xs  <= '0;
      q_xe  <= '0;
      q_ys  <= '0;
      q_w   <= '0;
      q_h   <= '0;
      q_rot <= 2'd0;
    end else if (fresh) begin
      q_xs  <= r_xs;
      q_xe  <= r_xe;
      q_ys  <= r_ys;
      q_w   <= s_w;
      q_h   <= s_h;
      q_rot <= r_fx;
    end
  end

  // effective window: fresh setup bypasses the capture registers
  logic [COORD_W-1:0] e_xs, e_xe, e_ys;
  logic [COORD_W:0]   e_w, e_h;
  logic [1:0]         e_rot;

  always_comb begin
    e_xs  = fresh ? r_xs : q_xs;
    e_xe  = fresh ? r_xe : q_xe;
    e_ys  = fresh ? r_ys : q_ys;
    e_w   = fresh ? s_w  : q_w;
    e_h   = fresh ? s_h  : q_h;
    e_rot = fresh ? r_fx : q_rot;
  end

  wl_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(load_ev), .arm(arm_ev), .step(step_ev),
    .total(s_total), .busy(busy), .done(done), .last(last_ev)
  );

  wl_cursor #(.COORD_W(COORD_W), .PANEL_W(PANEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cursor (
    .clk(clk), .rst_n(rst_n), .load(load_ev), .arm(arm_ev), .step(step_ev),
    .e_xs(e_xs), .e_xe(e_xe), .e_ys(e_ys), .e_rot(e_rot), .word(dat_word),
    .fb_we(fb_we), .fb_addr(fb_addr), .fb_word(fb_word),
    .fb_angle(fb_angle), .fb_rot(fb_rot)
  );

  wl_dirty #(.COORD_W(COORD_W)) u_dirty (
    .clk(clk), .rst_n(rst_n), .commit(last_ev),
    .xs(e_xs), .ys(e_ys), .w(e_w), .h(e_h),
    .x0(dirty_x0), .y0(dirty_y0), .x1(dirty_x1), .y1(dirty_y1)
  );

  // R5
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && !busy && !src_wr && !s_ok) |=> !fb_we);

  // R6
  fb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> $past(dat_we));

  // R4
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> busy);

endmodule

// File: tb/sim_win_loader.sv
`timescale 1ns/1ps
module sim_win_loader;
  localparam int COORD_W = 10;
  localparam int PANEL_W = 640;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = $clog2(PANEL_W * (1 << COORD_W));
  localparam int EMPTY   = (1 << (COORD_W + 1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_sel = 3'd0;
  logic [COORD_W-1:0] reg_wdata = '0;
  logic dat_we = 1'b0;
  logic [DATA_W-1:0] dat_word = '0;
  logic busy, done, fb_we, fb_rot;
  logic [ADDR_W-1:0] fb_addr;
  logic [DATA_W-1:0] fb_word;
  logic [1:0] fb_angle;
  logic [COORD_W:0] dirty_x0, dirty_y0, dirty_x1, dirty_y1;

  always #2.5 clk = ~clk;

  win_loader #(.COORD_W(COORD_W), .PANEL_W(PANEL_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .dat_we(dat_we), .dat_word(dat_word), .busy(busy), .done(done), .fb_we(fb_we),
    .fb_addr(fb_addr), .fb_word(fb_word), .fb_angle(fb_angle), .fb_rot(fb_rot),
    .dirty_x0(dirty_x0), .dirty_y0(dirty_y0), .dirty_x1(dirty_x1), .dirty_y1(dirty_y1)
  );

  typedef struct packed {
    logic [9:0] xs, xe, ys, ye;
    logic [3:0] fmt;
    logic [2:0] src;
    logic [1:0] fx;
    logic [7:0] words;
    logic       ok;
    logic [10:0] dx0, dy0, dx1, dy1;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{10'd2,  10'd4,  10'd1, 10'd2, 4'd1, 3'd0, 2'd0, 8'd6, 1'b1, 11'd2, 11'd1, 11'd5,  11'd3},
    '{10'd10, 10'd10, 10'd5, 10'd5, 4'd2, 3'd0, 2'd1, 8'd1, 1'b1, 11'd2, 11'd1, 11'd11, 11'd6},
    '{10'd0,  10'd3,  10'd0, 10'd0, 4'd7, 3'd0, 2'd2, 8'd8, 1'b1, 11'd0, 11'd0, 11'd11, 11'd6},
    '{10'd1,  10'd2,  10'd7, 10'd8, 4'd3, 3'd1, 2'd3, 8'd6, 1'b1, 11'd0, 11'd0, 11'd11, 11'd9},
    '{10'd0,  10'd1,  10'd0, 10'd0, 4'd0, 3'd0, 2'd0, 8'd0, 1'b0, 11'd0, 11'd0, 11'd11, 11'd9},
    '{10'd0,  10'd1,  10'd0, 10'd0, 4'd1, 3'd4, 2'd0, 8'd0, 1'b0, 11'd0, 11'd0, 11'd11, 11'd9},
    '{10'd5,  10'd4,  10'd0, 10'd0, 4'd1, 3'd0, 2'd0, 8'd0, 1'b0, 11'd0, 11'd0, 11'd11, 11'd9},
    '{10'd0,  10'd0,  10'd3, 10'd2, 4'd1, 3'd0, 2'd0, 8'd0, 1'b0, 11'd0, 11'd0, 11'd11, 11'd9},
    '{10'd20, 10'd21, 10'd3, 10'd3, 4'd6, 3'd3, 2'd0, 8'd4, 1'b1, 11'd0, 11'd0, 11'd22, 11'd9},
    '{10'd0,  10'd1,  10'd0, 10'd0, 4'd8, 3'd0, 2'd0, 8'd0, 1'b0, 11'd0, 11'd0, 11'd22, 11'd9}
  };

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit good, input string tag, input longint act, input longint exp);
    total++;
    if (!good) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input longint act, input longint exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic wr_reg(input int sel, input int val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'(sel); reg_wdata = COORD_W'(val);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic put_word(input int val);
    @(negedge clk);
    dat_we = 1'b1; dat_word = DATA_W'(val);
    @(negedge clk);
    dat_we = 1'b0;
  endtask

  task automatic set_win(input int xs, input int xe, input int ys, input int ye,
                         input int fmt, input int fx);
    wr_reg(0, xs); wr_reg(1, xe); wr_reg(2, ys); wr_reg(3, ye);
    wr_reg(4, fmt); wr_reg(6, fx);
  endtask

  task automatic chk_dirty(input string tag, input int x0, input int y0, input int x1, input int y1);
    eq(tag, dirty_x0, x0); eq(tag, dirty_y0, y0);
    eq(tag, dirty_x1, x1); eq(tag, dirty_y1, y1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    eq("R10 busy", busy, 0); eq("R10 done", done, 0); eq("R10 fb_we", fb_we, 0);
    chk_dirty("R7 reset box", EMPTY, EMPTY, 0, 0);
    rst_n = 1'b1;

    // vector table walk
    for (int v = 0; v < 10; v++) begin
      int cx, cy;
      set_win(TBL[v].xs, TBL[v].xe, TBL[v].ys, TBL[v].ye, TBL[v].fmt, TBL[v].fx);
      wr_reg(5, TBL[v].src);
      if (TBL[v].ok) begin
        eq("R4 busy after source write", busy, 1);
        cx = TBL[v].xs; cy = TBL[v].ys;
        for (int k = 0; k < TBL[v].words; k++) begin
          bit lastw;
          lastw = (k == TBL[v].words - 1);
          put_word(v * 256 + k);
          eq("R6 fb_we", fb_we, 1);
          eq("R6 fb_addr", fb_addr, cy * PANEL_W + cx);
          eq("R6 fb_word", fb_word, v * 256 + k);
          eq("R8 fb_angle", fb_angle, TBL[v].fx);
          eq("R8 fb_rot", fb_rot, TBL[v].fx != 0);
          eq("R3 done", done, lastw);
          eq("R3 busy", busy, !lastw);
          if (cx == TBL[v].xe) begin cx = TBL[v].xs; cy++; end else cx++;
        end
      end else begin
        eq("R1 R2 rejected setup busy", busy, 0);
        put_word(v);
        eq("R5 dropped word fb_we", fb_we, 0);
        eq("R5 dropped word busy", busy, 0);
        eq("R5 dropped word done", done, 0);
      end
      chk_dirty("R7 box after vector", TBL[v].dx0, TBL[v].dy0, TBL[v].dx1, TBL[v].dy1);
    end

    // R5 auto-arm by a bare data word, two-word window
    set_win(30, 31, 40, 40, 1, 0);
    put_word(16'h1111);
    eq("R5 auto-arm busy", busy, 1);
    eq("R5 auto-arm fb_we", fb_we, 1);
    eq("R6 auto-arm addr", fb_addr, 40 * PANEL_W + 30);
    put_word(16'h2222);
    eq("R3 auto-arm done", done, 1);
    eq("R6 auto-arm second addr", fb_addr, 40 * PANEL_W + 31);
    @(negedge clk);
    eq("R3 done lasts one cycle", done, 0);
    chk_dirty("R7 box after auto-arm", 0, 0, 32, 41);

    // R5 single-word window armed and committed by the same word
    set_win(50, 50, 2, 2, 2, 0);
    put_word(16'h3333);
    eq("R5 single word done", done, 1);
    eq("R5 single word busy", busy, 0);
    eq("R6 single word addr", fb_addr, 2 * PANEL_W + 50);
    chk_dirty("R7 box after single word", 0, 0, 51, 41);

    // R9 captured extents, R2 rejected source write mid-transfer
    set_win(0, 1, 60, 60, 1, 1);
    wr_reg(5, 0);
    put_word(16'h4444);
    eq("R6 first addr", fb_addr, 60 * PANEL_W);
    eq("R8 rotated path", fb_rot, 1);
    wr_reg(1, 5);
    wr_reg(5, 7);
    eq("R2 mid-transfer reject keeps busy", busy, 1);
    put_word(16'h5555);
    eq("R9 extent kept addr", fb_addr, 60 * PANEL_W + 1);
    eq("R9 length kept done", done, 1);
    chk_dirty("R7 box after captured window", 0, 0, 51, 61);

    // R4 restart mid-transfer
    set_win(0, 1, 0, 0, 1, 0);
    wr_reg(5, 0);
    put_word(16'h0a0a);
    eq("R6 restart first addr", fb_addr, 0);
    wr_reg(5, 0);
    put_word(16'h0b0b);
    eq("R4 restart cursor reload", fb_addr, 0);
    eq("R4 restart count busy", busy, 1);
    eq("R4 restart count done", done, 0);
    put_word(16'h0c0c);
    eq("R4 restart final addr", fb_addr, 1);
    eq("R4 restart final done", done, 1);

    // R10 reset during an open transfer
    wr_reg(5, 0);
    eq("R4 busy before reset", busy, 1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    eq("R10 busy after reset", busy, 0);
    chk_dirty("R7 box after reset", EMPTY, EMPTY, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule